// File: doc/BRIEF.md
# Multiple Exception Acceptance Sequencer

This block decides, one detection pass per clock cycle, which of several pending exceptions, interrupts and traps a processor accepts next. Synchronous events arrive as one-cycle pulses and are held as pending bits. The maskable interrupt and the user non-maskable interrupt are level-sensitive request lines that are sampled again on every pass. Each acceptance raises a one-cycle save strobe that carries the status values in force before the acceptance, gives the event code, and applies that event's rule to the interrupt enable flag, the level mask and the other pending events.

Passes repeat while anything can still be accepted. The first pass that accepts nothing ends the chain and reports the code of the most recently accepted event, which is the handler the processor starts first. Handlers therefore run in last-accepted-first order. While no chain is running, the block reads the processor's enable flag and level mask from its inputs. During a chain it works on its own copies, which it presents on its outputs when the chain ends.

Top module: `eit_accept_seq`

## Requirements
- R1: Acceptance priority follows the event code, lowest code first: 0 reset, 1 instruction break, 2 debug trap instruction, 3 undefined instruction, 4 software trap (INT instruction or coprocessor), 5 memory protection violation, 6 maskable interrupt, 7 user NMI, 8 emulator NMI, 9 step trace, 10 operand break.
- R2: Bit n of the pulse input sets the pending bit of the held event with code n, and that bit stays set until it is accepted or cancelled. Pulses on bits 6 and 7 have no effect.
- R3: Accepting reset clears every pending bit, including any pulses that arrive in the same cycle. The enable flag and the level mask are left unchanged.
- R4: Accepting code 1, 2, 8, 9 or 10 cancels all other pending bits and sets the level mask to 4.
- R5: Accepting code 3 cancels all other pending bits and clears the enable flag.
- R6: Accepting code 4 or 5 clears the enable flag and leaves the other pending bits in place.
- R7: The maskable interrupt can be accepted only when the enable flag is 1 and its level is numerically below the level mask. Accepting it loads the level mask with that level.
- R8: The user NMI can be accepted only when its fixed level of 15 is below the level mask, whatever the enable flag. Accepting it sets the mask to 15.
- R9: Each acceptance asserts the save strobe for exactly one cycle, together with the enable flag and mask that were in force before that acceptance. After reset no strobe is asserted.
- R10: In the first cycle after a chain in which nothing is acceptable, a one-cycle done pulse reports the code of the last accepted event and the final flag and mask. If nothing was accepted, no done pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_pulse_i | input | 11 | One-cycle request pulses, bit n for the event with code n |
| irq_req_i | input | 1 | Maskable interrupt request (level) |
| irq_lvl_i | input | 5 | Level of the maskable interrupt |
| nmi_req_i | input | 1 | User NMI request (level) |
| ien_i | input | 1 | Processor's interrupt enable flag, used outside a chain |
| mask_i | input | 5 | Processor's level mask, used outside a chain |
| save_o | output | 1 | Save strobe: one event accepted this cycle |
| save_ien_o | output | 1 | Enable flag before this acceptance |
| save_mask_o | output | 5 | Level mask before this acceptance |
| acc_vec_o | output | 4 | Code of the event accepted this cycle |
| done_o | output | 1 | Chain finished; start the handler |
| done_vec_o | output | 4 | Code of the last accepted event |
| ien_o | output | 1 | Enable flag after the chain |
| mask_o | output | 5 | Level mask after the chain |

## Verification
The bench builds the block with its default parameters: a 5-bit level, an NMI level of 15 and a cancel level of 4. These values let a mask of 20 admit both interrupt kinds, so the order in which they compete is visible. They also let a cancelling event's forced mask of 4 and the NMI's own mask of 15 be seen to block further acceptances within the same chain. Table vectors mix held pulses with level requests to expose priority, cancellation, flag clearing and last-accepted reporting. Directed cases cover the reset state and the values that accompany the save strobe.

// File: rtl/eit_seq_pkg.sv
`timescale 1ns/1ps
package eit_seq_pkg;
  localparam int NEV = 11;
  localparam int VW  = $clog2(NEV);

  typedef enum logic [VW-1:0] {
    EV_RST = 4'd0, EV_IBRK, EV_DTRAP, EV_UNDEF, EV_SWTRAP, EV_MPROT,
    EV_IRQ, EV_UNMI, EV_ENMI, EV_STEP, EV_OBRK
  } ev_e;

  typedef enum logic [2:0] {
    FX_CLEAR_ALL, FX_CANCEL_LVL, FX_CANCEL_IEN, FX_IEN_OFF, FX_LOAD_LVL, FX_NMI_LVL
  } fx_e;

  // events held as pending bits; the two interrupt lines are level inputs
  localparam logic [NEV-1:0] HELD_EV = 11'b111_0011_1111;

  function automatic fx_e fx_of(input logic [VW-1:0] code);
    case (code)
      EV_RST:                                  return FX_CLEAR_ALL;
      EV_IBRK, EV_DTRAP, EV_ENMI, EV_STEP, EV_OBRK: return FX_CANCEL_LVL;
      EV_UNDEF:                                return FX_CANCEL_IEN;
      EV_IRQ:                                  return FX_LOAD_LVL;
      EV_UNMI:                                 return FX_NMI_LVL;
      default:                                 return FX_IEN_OFF;
    endcase
  endfunction
endpackage

// File: rtl/eit_pend.sv
`timescale 1ns/1ps
module eit_pend #(
  parameter int NEV = 11,
  parameter logic [NEV-1:0] HELD = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  input  logic           clr_all_i,
  output logic [NEV-1:0] pend_o
);
  logic [NEV-1:0] pend_q, pend_d;

  always_comb begin
    if (clr_all_i) pend_d = '0;
    else           pend_d = (pend_q & ~clr_i) | (set_i & HELD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/eit_pick.sv
`timescale 1ns/1ps
module eit_pick #(
  parameter int NEV = 11,
  localparam int VW = $clog2(NEV)
) (
  input  logic [NEV-1:0] req_i,
  output logic [NEV-1:0] gnt_o,
  output logic           any_o,
  output logic [VW-1:0]  code_o
);
  // lowest index wins: scan downward so the last hit is the winner
  always_comb begin
    gnt_o  = '0;
    code_o = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        code_o   = VW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/eit_mask.sv
`timescale 1ns/1ps
module eit_mask
  import eit_seq_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int NMI_LVL    = 15,
  parameter int CANCEL_LVL = 4
) (
  input  fx_e              fx_i,
  input  logic             ien_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  output logic             ien_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             cancel_o,
  output logic             clr_all_o
);
  always_comb begin
    ien_o     = ien_i;
    mask_o    = mask_i;
    cancel_o  = 1'b0;
    clr_all_o = 1'b0;
    case (fx_i)
      FX_CLEAR_ALL:  clr_all_o = 1'b1;
      FX_CANCEL_LVL: begin cancel_o = 1'b1; mask_o = LVL_W'(CANCEL_LVL); end
      FX_CANCEL_IEN: begin cancel_o = 1'b1; ien_o = 1'b0; end
      FX_IEN_OFF:    ien_o  = 1'b0;
      FX_LOAD_LVL:   mask_o = irq_lvl_i;
      FX_NMI_LVL:    mask_o = LVL_W'(NMI_LVL);
      default:       ien_o  = ien_i;
    endcase
  end
endmodule

// File: rtl/eit_accept_seq.sv
`timescale 1ns/1ps
module eit_accept_seq
  import eit_seq_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int NMI_LVL    = 15,
  parameter int CANCEL_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEV-1:0]   exc_pulse_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             nmi_req_i,
  input  logic             ien_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             save_o,
  output logic             save_ien_o,
  output logic [LVL_W-1:0] save_mask_o,
  output logic [VW-1:0]    acc_vec_o,
  output logic             done_o,
  output logic [VW-1:0]   done_vec_o,
  output logic             ien_o,
  output logic [LVL_W-1:0] mask_o
);
  localparam logic [LVL_W-1:0] NMI_L = LVL_W'(NMI_LVL);

  logic             in_chain_q, in_chain_d;
  logic [VW-1:0]    last_q, last_d;
  logic             ien_q, ien_d;
  logic [LVL_W-1:0] mask_q, mask_d;
  logic             upd_en;

  logic             cur_ien;
  logic [LVL_W-1:0] cur_mask;
  logic [NEV-1:0]   pend_q, req, gnt, pend_clr;
  logic             any;
  logic [VW-1:0]    code;
  fx_e              fx;
  logic             ien_nx, cancel, clr_all;
  logic [LVL_W-1:0] mask_nx;

  // outside a chain the processor's own status is in force
  assign cur_ien  = in_chain_q ? ien_q  : ien_i;
  assign cur_mask = in_chain_q ? mask_q : mask_i;

  always_comb begin
    req          = pend_q;
    req[EV_IRQ]  = irq_req_i & cur_ien & (irq_lvl_i < cur_mask);
    req[EV_UNMI] = nmi_req_i & (NMI_L < cur_mask);
  end

  eit_pick #(.NEV(NEV)) u_pick (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (any),
    .code_o(code)
  );

  assign fx = fx_of(code);

  eit_mask #(.LVL_W(LVL_W), .NMI_LVL(NMI_LVL), .CANCEL_LVL(CANCEL_LVL)) u_mask (
    .fx_i     (fx),
    .ien_i    (cur_ien),
    .mask_i   (cur_mask),
    .irq_lvl_i(irq_lvl_i),
    .ien_o    (ien_nx),
    .mask_o   (mask_nx),
    .cancel_o (cancel),
    .clr_all_o(clr_all)
  );

  assign pend_clr = !any ? '0 : (cancel ? '1 : gnt);

  eit_pend #(.NEV(NEV), .HELD(HELD_EV)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (exc_pulse_i),
    .clr_i    (pend_clr),
    .clr_all_i(any & clr_all),
    .pend_o   (pend_q)
  );

  // next state
  always_comb begin
    upd_en     = any;
    in_chain_d = any;
    ien_d      = ien_q;
    mask_d     = mask_q;
    last_d     = last_q;
    if (upd_en) begin
      ien_d  = ien_nx;
      mask_d = mask_nx;
      last_d = code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_chain_q <= 1'b0;
      ien_q      <= 1'b0;
      mask_q     <= '0;
      last_q     <= '0;
    end else begin
      in_chain_q <= in_chain_d;
      if (upd_en) begin
        ien_q  <= ien_d;
        mask_q <= mask_d;
        last_q <= last_d;
      end
    end
  end

  assign save_o      = any;
  assign save_ien_o  = cur_ien;
  assign save_mask_o = cur_mask;
  assign acc_vec_o   = code;
  assign done_o      = in_chain_q & ~any;
  assign done_vec_o  = last_q;
  assign ien_o       = ien_q;
  assign mask_o      = mask_q;
endmodule

// File: rtl/eit_seq_chk.sv
`timescale 1ns/1ps
module eit_seq_chk
  import eit_seq_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int NMI_LVL    = 15,
  parameter int CANCEL_LVL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] irq_lvl_i,
  input logic             save_o,
  input logic [VW-1:0]    acc_vec_o,
  input logic             done_o,
  input logic [VW-1:0]    done_vec_o,
  input logic             ien_o,
  input logic [LVL_W-1:0] mask_o,
  input logic [NEV-1:0]   pend_i
);
  // R3
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && acc_vec_o == EV_RST) |=> (pend_i == '0));

  // R4
  cancel_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && (acc_vec_o == EV_IBRK || acc_vec_o == EV_DTRAP || acc_vec_o == EV_ENMI ||
                acc_vec_o == EV_STEP || acc_vec_o == EV_OBRK))
    |=> (mask_o == LVL_W'(CANCEL_LVL)));

  // R5
  undef_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && acc_vec_o == EV_UNDEF) |=> !ien_o);

  // R6
  trap_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && (acc_vec_o == EV_SWTRAP || acc_vec_o == EV_MPROT)) |=> !ien_o);

  // R7
  irq_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && acc_vec_o == EV_IRQ) |=> (mask_o == $past(irq_lvl_i)));

  // R8
  nmi_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && acc_vec_o == EV_UNMI) |=> (mask_o == LVL_W'(NMI_LVL)));

  // R10
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(save_o) && done_vec_o == $past(acc_vec_o)));

  // R2
  held_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i[EV_IRQ] == 1'b0 && pend_i[EV_UNMI] == 1'b0));
endmodule

bind eit_accept_seq eit_seq_chk #(
  .LVL_W(LVL_W), .NMI_LVL(NMI_LVL), .CANCEL_LVL(CANCEL_LVL)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lvl_i (irq_lvl_i),
  .save_o    (save_o),
  .acc_vec_o (acc_vec_o),
  .done_o    (done_o),
  .done_vec_o(done_vec_o),
  .ien_o     (ien_o),
  .mask_o    (mask_o),
  .pend_i    (pend_q)
);

// File: tb/test_eit_accept_seq.sv
`timescale 1ns/1ps
module test_eit_accept_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] exc_pulse;
  logic        irq_req, nmi_req, ien_in;
  logic [4:0]  irq_lvl, mask_in;
  logic        save, save_ien, done, ien_out;
  logic [4:0]  save_mask, mask_out;
  logic [3:0]  acc_vec, done_vec;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  eit_accept_seq i_eit_accept_seq (
    .clk(clk), .rst_n(rst_n), .exc_pulse_i(exc_pulse), .irq_req_i(irq_req),
    .irq_lvl_i(irq_lvl), .nmi_req_i(nmi_req), .ien_i(ien_in), .mask_i(mask_in),
    .save_o(save), .save_ien_o(save_ien), .save_mask_o(save_mask), .acc_vec_o(acc_vec),
    .done_o(done), .done_vec_o(done_vec), .ien_o(ien_out), .mask_o(mask_out)
  );

  typedef struct packed {
    logic [10:0] pul;
    logic        irq;
    logic [4:0]  lvl;
    logic        nmi;
    logic        ien;
    logic [4:0]  msk;
    logic [1:0]  n;
    logic [3:0]  v0;
    logic [3:0]  v1;
    logic        fien;
    logic [4:0]  fmsk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{11'h228, 1'b1, 5'd3, 1'b0, 1'b1, 5'd20, 2'd1, 4'd3, 4'd0, 1'b0, 5'd20},
    '{11'h030, 1'b1, 5'd3, 1'b0, 1'b1, 5'd20, 2'd2, 4'd4, 4'd5, 1'b0, 5'd20},
    '{11'h000, 1'b1, 5'd7, 1'b0, 1'b1, 5'd10, 2'd1, 4'd6, 4'd0, 1'b1, 5'd7},
    '{11'h000, 1'b1, 5'd3, 1'b1, 1'b1, 5'd20, 2'd1, 4'd6, 4'd0, 1'b1, 5'd3},
    '{11'h000, 1'b0, 5'd0, 1'b1, 1'b0, 5'd20, 2'd1, 4'd7, 4'd0, 1'b0, 5'd15},
    '{11'h600, 1'b0, 5'd0, 1'b0, 1'b1, 5'd20, 2'd1, 4'd9, 4'd0, 1'b1, 5'd4},
    '{11'h120, 1'b1, 5'd2, 1'b0, 1'b1, 5'd20, 2'd2, 4'd5, 4'd8, 1'b0, 5'd4},
    '{11'h00B, 1'b0, 5'd0, 1'b0, 1'b1, 5'd20, 2'd1, 4'd0, 4'd0, 1'b1, 5'd20},
    '{11'h006, 1'b0, 5'd0, 1'b0, 1'b1, 5'd20, 2'd1, 4'd1, 4'd0, 1'b1, 5'd4},
    '{11'h000, 1'b1, 5'd3, 1'b0, 1'b1, 5'd3,  2'd0, 4'd0, 4'd0, 1'b0, 5'd0},
    '{11'h0C0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd20, 2'd0, 4'd0, 4'd0, 1'b0, 5'd0},
    '{11'h010, 1'b0, 5'd0, 1'b1, 1'b1, 5'd20, 2'd2, 4'd4, 4'd7, 1'b0, 5'd15},
    '{11'h000, 1'b1, 5'd2, 1'b1, 1'b0, 5'd20, 2'd1, 4'd7, 4'd0, 1'b0, 5'd15}
  };
  localparam string TAG [NV] = '{"R5", "R6", "R7", "R1", "R8", "R4", "R6",
                                 "R3", "R4", "R7", "R2", "R10", "R8"};

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; exc_pulse = '0; irq_req = 1'b0; nmi_req = 1'b0;
    irq_lvl = '0; ien_in = 1'b0; mask_in = '0;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state: no strobe, no done, cleared status
    chk(save == 1'b0, "R9", "reset save", int'(save), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);
    chk(mask_out == 5'd0 && ien_out == 1'b0, "R9", "reset status", int'(mask_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int e = 0; e < NV; e++) begin
      int got;
      bit seen_done;
      logic [3:0] g0, g1, dv;
      logic fi;
      logic [4:0] fm;
      got = 0; seen_done = 1'b0; g0 = '0; g1 = '0; dv = '0; fi = 1'b0; fm = '0;
      exc_pulse = TBL[e].pul; ien_in = TBL[e].ien; mask_in = TBL[e].msk;
      @(negedge clk);
      exc_pulse = '0; irq_req = TBL[e].irq; irq_lvl = TBL[e].lvl; nmi_req = TBL[e].nmi;
      for (int c = 0; c < 8 && !seen_done; c++) begin
        #1;
        if (save) begin
          if (got == 0) g0 = acc_vec; else g1 = acc_vec;
          got++;
        end
        if (done) begin
          seen_done = 1'b1; dv = done_vec; fi = ien_out; fm = mask_out;
        end
        @(negedge clk);
      end
      irq_req = 1'b0; nmi_req = 1'b0;
      chk(got == int'(TBL[e].n), TAG[e], $sformatf("entry %0d accepts", e), got, int'(TBL[e].n));
      chk(seen_done == (TBL[e].n != 0), TAG[e], $sformatf("entry %0d done seen", e),
          int'(seen_done), int'(TBL[e].n != 0));
      if (TBL[e].n >= 1)
        chk(g0 == TBL[e].v0, TAG[e], $sformatf("entry %0d first code", e), int'(g0), int'(TBL[e].v0));
      if (TBL[e].n == 2)
        chk(g1 == TBL[e].v1, TAG[e], $sformatf("entry %0d second code", e), int'(g1), int'(TBL[e].v1));
      if (TBL[e].n != 0) begin
        logic [3:0] lastv;
        lastv = (TBL[e].n == 2) ? TBL[e].v1 : TBL[e].v0;
        // R10 done reports the most recent acceptance
        chk(dv == lastv, TAG[e], $sformatf("entry %0d done code", e), int'(dv), int'(lastv));
        chk(fi == TBL[e].fien, TAG[e], $sformatf("entry %0d final enable", e), int'(fi), int'(TBL[e].fien));
        chk(fm == TBL[e].fmsk, TAG[e], $sformatf("entry %0d final mask", e), int'(fm), int'(TBL[e].fmsk));
      end
      repeat (2) @(negedge clk);
    end

    // R9 pre-update values on the strobe, strobe lasts one cycle
    ien_in = 1'b1; mask_in = 5'd12; irq_lvl = 5'd5; irq_req = 1'b1;
    #1;
    chk(save == 1'b1 && acc_vec == 4'd6, "R9", "strobe on irq", int'(save), 1);
    chk(save_mask == 5'd12, "R9", "saved mask", int'(save_mask), 12);
    chk(save_ien == 1'b1, "R9", "saved enable", int'(save_ien), 1);
    @(negedge clk);
    #1;
    chk(save == 1'b0, "R9", "strobe one cycle", int'(save), 0);
    chk(done == 1'b1 && mask_out == 5'd5, "R7", "mask loaded from level", int'(mask_out), 5);
    @(negedge clk);
    irq_req = 1'b0;
    repeat (2) @(negedge clk);

    // R2 pulse on a level-only position leaves nothing pending
    exc_pulse = 11'h040; ien_in = 1'b1; mask_in = 5'd20;
    @(negedge clk);
    exc_pulse = '0;
    repeat (3) begin
      #1;
      chk(save == 1'b0 && done == 1'b0, "R2", "ignored pulse", int'(save), 0);
      @(negedge clk);
    end

    summary();
    $finish;
  end
endmodule